// File: doc/BRIEF.md
# Diagnostic Signal Force Multiplexer

This block sits between a chip's internal logic and twelve of its signals so that test software can disturb exactly one of them at a time. A single control-word write picks a target signal with a 4-bit selection field and an action with a 2-bit mode field. The action can leave the target untouched, pin it high, pin it low, or inject one pulse that is exactly one clock wide. Forcing or pulsing a signal lets error, parity and sync-recovery paths be exercised on purpose.

A pulse is armed by the write and fires on the first later clock edge where the module-clock-running flag is high. It then returns the signal to its normal value without any further write. Signals that are not selected always pass straight through. The outputs are combinational from the signal inputs, so the block adds no latency to normal traffic. All ports are plain control or data pins; there is no stream handshake.

Top module: `force_mux_top`

## Requirements
- R1: While reset is applied and after its release with no write, the mode is pass-through and every output equals its input.
- R2: A signal whose index differs from the selection code always outputs its input value, whatever the mode.
- R3: Selection code k (0 to 11) targets output bit k. Bits 0 to 5 are the six glue lines of chip 0, bit 6 is chip 0 multipurpose A, bit 7 is chip 0 multipurpose B, bit 8 is chip 1 multipurpose A, bit 9 is chip 1 multipurpose B, bit 10 is chip 0 interface data and bit 11 is chip 0 sync.
- R4: Selection codes 12 to 15 target nothing, and all outputs equal their inputs in every mode.
- R5: Mode 1 drives the selected output to 1.
- R6: Mode 2 drives the selected output to 0.
- R7: Mode 0 passes the selected signal through unchanged.
- R8: In mode 3 the selected output is 1 for exactly one clock cycle. That cycle follows the first rising edge after the write at which the clock-running flag is 1. No pulse fires at edges where the flag is 0.
- R9: After its single pulse, a mode-3 target passes its input through until the next mode-3 write.
- R10: Any new control write replaces the previous selection and mode and cancels a pulse that is armed or in progress.
- R11: The control word is sampled only when the write strobe is 1. The selection is bits 19:16 and the mode is bits 21:20. All other bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_run | input | 1 | Module clock is running; gates pulse firing |
| ctl_we | input | 1 | Control-word write strobe |
| ctl_word | input | 32 | Control word (selection 19:16, mode 21:20) |
| sig_in | input | 12 | Normal signal values |
| sig_out | output | 12 | Signal values after optional override |

## Verification
The bench builds the block with its default parameters: twelve signals and a 4-bit selection field at bit 16 with the mode at bit 20. This leaves four selection codes that target nothing, so R4 can be reached by random and directed writes alike. Random control words also carry random bits outside both fields, which tests R11. Directed sequences hold the clock-running flag low after arming a pulse, overwrite an armed pulse, and count pulse cycles. These cover the timing and cancellation corners of R8 to R10.

// File: rtl/fm_pkg.sv
package fm_pkg;
  typedef enum logic [1:0] {
    FM_PASS  = 2'd0,
    FM_HIGH  = 2'd1,
    FM_LOW   = 2'd2,
    FM_PULSE = 2'd3
  } fm_mode_e;
endpackage

// File: rtl/fm_sel_decode.sv
// Turns the selection code into one enable per lane; codes past the last lane hit nothing (R4).
module fm_sel_decode #(
  parameter int N_SIG = 12,
  parameter int SEL_W = 4
) (
  input  logic [SEL_W-1:0] sel,
  output logic [N_SIG-1:0] hit
);
  for (genvar i = 0; i < N_SIG; i++) begin : g_hit
    assign hit[i] = (sel == SEL_W'(i));
  end
endmodule

// File: rtl/fm_oneshot.sv
// Arms on a mode-3 write, fires one cycle on the next running edge (R8, R9, R10).
module fm_oneshot (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic arm,
  input  logic run,
  output logic pulse
);
  logic armed_q, pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      pulse_q <= 1'b0;
    end else if (load) begin
      armed_q <= arm;
      pulse_q <= 1'b0;
    end else if (armed_q && run) begin
      armed_q <= 1'b0;
      pulse_q <= 1'b1;
    end else begin
      pulse_q <= 1'b0;
    end
  end

  assign pulse = pulse_q;

  p_pulse_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);
  p_pulse_needs_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_q) |-> $past(run) && $past(armed_q));
  p_write_cancels_r10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !pulse_q);
endmodule

// File: rtl/fm_lane.sv
// One signal lane: apply the override only when this lane is the target.
module fm_lane
  import fm_pkg::*;
(
  input  logic     in_bit,
  input  logic     hit,
  input  fm_mode_e mode,
  input  logic     pulse,
  output logic     out_bit
);
  logic forced;

  always_comb begin
    unique case (mode)
      FM_HIGH:  forced = 1'b1;
      FM_LOW:   forced = 1'b0;
      FM_PULSE: forced = pulse | in_bit;
      default:  forced = in_bit;
    endcase
    out_bit = hit ? forced : in_bit;
  end
endmodule

// File: rtl/force_mux_top.sv
module force_mux_top
  import fm_pkg::*;
#(
  parameter int N_SIG    = 12,
  parameter int SEL_W    = 4,
  parameter int WORD_W   = 32,
  parameter int SEL_LSB  = 16,
  parameter int MODE_LSB = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_run,
  input  logic              ctl_we,
  input  logic [WORD_W-1:0] ctl_word,
  input  logic [N_SIG-1:0]  sig_in,
  output logic [N_SIG-1:0]  sig_out
);
  localparam int MODE_W = 2;

  logic [SEL_W-1:0] sel_q;
  fm_mode_e         mode_q;
  fm_mode_e         mode_wr;
  logic [N_SIG-1:0] hit;
  logic             pulse;

  assign mode_wr = fm_mode_e'(ctl_word[MODE_LSB +: MODE_W]);

  // R11: fields captured only on a write strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      mode_q <= FM_PASS;
    end else if (ctl_we) begin
      sel_q  <= ctl_word[SEL_LSB +: SEL_W];
      mode_q <= mode_wr;
    end
  end

  fm_sel_decode #(.N_SIG(N_SIG), .SEL_W(SEL_W)) u_dec (
    .sel (sel_q),
    .hit (hit)
  );

  fm_oneshot u_shot (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (ctl_we),
    .arm   (mode_wr == FM_PULSE),
    .run   (clk_run),
    .pulse (pulse)
  );

  for (genvar i = 0; i < N_SIG; i++) begin : g_lane
    fm_lane u_lane (
      .in_bit  (sig_in[i]),
      .hit     (hit[i]),
      .mode    (mode_q),
      .pulse   (pulse),
      .out_bit (sig_out[i])
    );
  end

  p_single_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));
  p_unselected_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((sig_out ^ sig_in) & ~hit) == '0);
  p_off_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == FM_PASS) |-> (sig_out == sig_in));
  p_force_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == FM_HIGH) |-> ((sig_out & hit) == hit));
  p_force_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == FM_LOW) |-> ((sig_out & hit) == '0));
  p_no_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q >= SEL_W'(N_SIG)) |-> (sig_out == sig_in));
endmodule

// File: tb/tb_force_mux_top.sv
module tb_force_mux_top;
  localparam int N = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_run = 1'b0;
  logic        ctl_we = 1'b0;
  logic [31:0] ctl_word = '0;
  logic [N-1:0] sig_in = '0;
  logic [N-1:0] sig_out;

  int checks = 0;
  int errors = 0;

  // bench model state
  logic [3:0] m_sel = '0;
  logic [1:0] m_mode = '0;
  logic       m_armed = 1'b0;
  logic       m_pulse = 1'b0;

  always #10 clk = ~clk;

  force_mux_top dut (
    .clk(clk), .rst_n(rst_n), .clk_run(clk_run), .ctl_we(ctl_we),
    .ctl_word(ctl_word), .sig_in(sig_in), .sig_out(sig_out)
  );

  function automatic logic [N-1:0] expect_out(logic [N-1:0] sin);
    logic [N-1:0] r;
    r = sin;
    if (m_sel < 4'd12) begin  // R3 index k targets bit k; R4 codes 12..15 nothing
      case (m_mode)
        2'd1: r[m_sel] = 1'b1;            // R5
        2'd2: r[m_sel] = 1'b0;            // R6
        2'd3: r[m_sel] = sin[m_sel] | m_pulse; // R8
        default: ;                        // R7
      endcase
    end
    return r;
  endfunction

  function automatic string tag_now();
    if (!rst_n) return "R1";
    if (m_sel >= 4'd12) return "R4";
    case (m_mode)
      2'd1: return "R5";
      2'd2: return "R6";
      2'd3: return "R8";
      default: return "R7";
    endcase
  endfunction

  task automatic check_out();
    logic [N-1:0] e;
    e = expect_out(sig_in);
    checks++;
    if (sig_out !== e) begin
      errors++;
      $display("FAIL %s (R2 lanes incl.) sig_out=%h expected=%h", tag_now(), sig_out, e);
    end
  endtask

  // one cycle: drive at negedge, check, then update model at posedge
  task automatic step(input logic we, input logic [31:0] w, input logic run,
                      input logic [N-1:0] sin);
    @(negedge clk);
    ctl_we = we; ctl_word = w; clk_run = run; sig_in = sin;
    #1 check_out();
    @(posedge clk);
    if (!rst_n) begin
      m_sel = '0; m_mode = '0; m_armed = 1'b0; m_pulse = 1'b0;
    end else if (we) begin  // R10, R11
      m_sel = w[19:16]; m_mode = w[21:20];
      m_armed = (w[21:20] == 2'd3); m_pulse = 1'b0;
    end else if (m_armed && run) begin
      m_armed = 1'b0; m_pulse = 1'b1;
    end else begin
      m_pulse = 1'b0;
    end
  endtask

  function automatic logic [31:0] cw(logic [1:0] mode, logic [3:0] sel);
    return {10'd0, mode, sel, 16'd0};
  endfunction

  task automatic count_check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s pulse count=%0d expected=%0d", tag, got, exp);
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int pc;
    void'($urandom(32'd4242));
    // R1: reset holds pass-through
    for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b1, N'($urandom));
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step(1'b0, '0, 1'b1, N'($urandom));

    // R3/R4/R5/R6: walk every code in force-high then force-low
    for (int s = 0; s < 16; s++) begin
      step(1'b1, cw(2'd1, 4'(s)), 1'b1, '0);
      step(1'b0, '0, 1'b1, '0);
      step(1'b1, cw(2'd2, 4'(s)), 1'b1, '1);
      step(1'b0, '0, 1'b1, '1);
    end

    // R8: pulse waits for clk_run, fires once (R9)
    step(1'b1, cw(2'd3, 4'd3), 1'b0, '0);
    pc = 0;
    for (int i = 0; i < 5; i++) begin
      step(1'b0, '0, 1'b0, '0);
      pc += sig_out[3];
    end
    count_check("R8", pc, 0);
    for (int i = 0; i < 6; i++) begin
      step(1'b0, '0, 1'b1, '0);
      pc += sig_out[3];
    end
    count_check("R9", pc, 1);

    // R10: armed pulse cancelled by a new write
    step(1'b1, cw(2'd3, 4'd11), 1'b0, '0);
    step(1'b1, cw(2'd0, 4'd11), 1'b1, '0);
    pc = 0;
    for (int i = 0; i < 4; i++) begin
      step(1'b0, '0, 1'b1, '0);
      pc += sig_out[11];
    end
    count_check("R10", pc, 0);

    // R11: strobe low ignores word; random bits outside fields
    for (int i = 0; i < 3000; i++) begin
      logic we;
      logic [31:0] w;
      we = ($urandom % 4) == 0;
      w = $urandom;
      if (($urandom % 3) == 0) w[21:20] = 2'd3;
      step(we, w, ($urandom % 4) != 0, N'($urandom));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule